// File: doc/BRIEF.md
# Dual Virtual-Channel Output Buffer

This block sits at one port of an on-chip switch and buffers packets for two virtual channels, one per traffic direction, so that forward and backward traffic share a single physical output link. Each channel has its own group of seven 92-bit entries. Because the groups are separate, a stalled or full channel never blocks the other one.

A writer presents a packet together with a channel-select bit. The read side drives the oldest packet of whichever channel the arbiter picks onto the shared link. When both channels hold data, the arbiter alternates between them. When only one channel holds data, that channel is served on every cycle the link is ready.

Flow control is token based. For each channel, the block keeps a count of the tokens the upstream sender holds. It starts at one token per entry, drops by one for each accepted packet and rises by one when an entry of that channel leaves. A return pulse for the channel accompanies each departure. A write to a channel with no free entry is a protocol error: the block flags it and drops the packet.

Top module: `vcbuf_top`

## Requirements
- R1: After reset, `rd_valid` and `ovf_err` are 0, both token counts are 7 and `tok_ret` is 0.
- R2: Each channel stores up to 7 packets of 92 bits. Data are returned bit-exact, and a full channel shows a token count of 0.
- R3: Within one channel, packets leave in the order they were accepted. `rd_data` shows the head of the channel named by `rd_vc` (0 = forward channel, 1 = backward channel).
- R4: The channels are independent. While channel 0 is full, writes to channel 1 are accepted, and channel 1 is read normally.
- R5: A channel's token count drops by 1 on each accepted write to it and rises by 1 on each read from it. The count is registered, so the change is visible the cycle after. `tok_ret[c]` is high in exactly the cycles in which channel c's head is consumed (`rd_valid && rd_ready && rd_vc == c`).
- R6: A write to a full channel is dropped and raises `ovf_err` for one cycle, in the cycle after the write. This holds even if that channel is read in the same cycle. The stored contents and the token count are unaffected.
- R7: When both channels hold data, each consumed packet comes from the channel not served by the previous consumed packet. After reset, channel 0 is treated as next.
- R8: `rd_valid` is high exactly when at least one channel holds data. If only one channel holds data, it is offered.
- R9: While `rd_ready` is low, nothing is consumed. `rd_vc`, `rd_data` and the token counts stay unchanged unless a write arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write strobe |
| wr_vc | input | 1 | Channel select for the write |
| wr_data | input | 92 | Packet to store |
| rd_ready | input | 1 | Shared link can take a packet this cycle |
| rd_valid | output | 1 | A packet is offered |
| rd_vc | output | 1 | Channel of the offered packet |
| rd_data | output | 92 | Offered packet |
| tok_ret | output | 2 | Per-channel token return pulse |
| tok_cnt0 | output | 3 | Tokens held by the channel 0 sender |
| tok_cnt1 | output | 3 | Tokens held by the channel 1 sender |
| ovf_err | output | 1 | Write to a full channel was dropped (one cycle later) |

## Verification
The hardest situation to reach is one channel sitting full while the other keeps moving. Alternation must then resume correctly once both channels hold data, including a write to the full channel in the same cycle that channel is read. Directed phases fill each channel past its limit with the link held off, then drain with the link open. A long pseudo-random sweep follows, mixing writes, channel choice and link readiness, with the link often stalled so that both channels frequently sit at the full boundary. Every cycle is compared against a queue model in the bench.

// File: rtl/vcbuf_pkg.sv
package vcbuf_pkg;
    localparam int NUM_VC = 2;

    typedef enum logic {
        VC_FWD = 1'b0,
        VC_BWD = 1'b1
    } vc_id_e;
endpackage

// File: rtl/vcbuf_fifo.sv
module vcbuf_fifo #(
    parameter int W     = 92,
    parameter int DEPTH = 7
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 push_data,
    input  logic                         pop,
    output logic [W-1:0]                 head,
    output logic                         empty,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   occ
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t s_q, s_d;
    logic [W-1:0] mem_q [DEPTH];

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d = s_q;
        if (push) s_d.wp = ptr_inc(s_q.wp);
        if (pop)  s_d.rp = ptr_inc(s_q.rp);
        s_d.cnt = s_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[s_q.wp] <= push_data;
    end

    assign head  = mem_q[s_q.rp];
    assign empty = (s_q.cnt == '0);
    assign full  = (s_q.cnt == CW'(DEPTH));
    assign occ   = s_q.cnt;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);   // R6
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);   // R3
endmodule

// File: rtl/vcbuf_tokens.sv
module vcbuf_tokens #(
    parameter int DEPTH = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       take,
    input  logic                       give,
    output logic [$clog2(DEPTH+1)-1:0] cnt
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q - CW'(take) + CW'(give);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= CW'(DEPTH);
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    AST_TOK_NO_EXCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (give && !take) |-> (cnt_q != CW'(DEPTH)));   // R5
    AST_TOK_NO_DEBT: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !give) |-> (cnt_q != '0));           // R5
endmodule

// File: rtl/vcbuf_arb.sv
module vcbuf_arb (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] have,
    input  logic       ready,
    output logic       valid,
    output logic       sel,
    output logic [1:0] pop
);
    logic last_q, last_d;
    logic fire;

    always_comb begin
        valid = |have;
        if (have == 2'b11) sel = ~last_q;
        else               sel = have[1];
        fire   = valid && ready;
        pop    = fire ? (2'b01 << sel) : 2'b00;
        last_d = fire ? sel : last_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b1;
        else        last_q <= last_d;
    end

    AST_ONE_POP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop));                                        // R7
    AST_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && have == 2'b11) |=> (have != 2'b11 || !ready || sel != $past(sel)));   // R7
endmodule

// File: rtl/vcbuf_top.sv
module vcbuf_top #(
    parameter int W     = 92,
    parameter int DEPTH = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_valid,
    input  logic                       wr_vc,
    input  logic [W-1:0]               wr_data,
    input  logic                       rd_ready,
    output logic                       rd_valid,
    output logic                       rd_vc,
    output logic [W-1:0]               rd_data,
    output logic [1:0]                 tok_ret,
    output logic [$clog2(DEPTH+1)-1:0] tok_cnt0,
    output logic [$clog2(DEPTH+1)-1:0] tok_cnt1,
    output logic                       ovf_err
);
    import vcbuf_pkg::*;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  head   [NUM_VC];
    logic [CW-1:0] occ    [NUM_VC];
    logic [CW-1:0] tok    [NUM_VC];
    logic [NUM_VC-1:0] empty, full, accept, pop;
    logic err_q, err_d;

    for (genvar c = 0; c < NUM_VC; c++) begin : g_vc
        assign accept[c] = wr_valid && (wr_vc == c[0]) && !full[c];

        vcbuf_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
            .clk(clk), .rst_n(rst_n),
            .push(accept[c]), .push_data(wr_data), .pop(pop[c]),
            .head(head[c]), .empty(empty[c]), .full(full[c]), .occ(occ[c])
        );

        vcbuf_tokens #(.DEPTH(DEPTH)) u_tok (
            .clk(clk), .rst_n(rst_n),
            .take(accept[c]), .give(pop[c]), .cnt(tok[c])
        );

        AST_TOK_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            (32'(tok[c]) + 32'(occ[c])) == DEPTH);   // R5
    end

    vcbuf_arb u_arb (
        .clk(clk), .rst_n(rst_n),
        .have(~empty), .ready(rd_ready),
        .valid(rd_valid), .sel(rd_vc), .pop(pop)
    );

    always_comb begin
        err_d = wr_valid && full[wr_vc];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_d;
    end

    assign rd_data  = head[rd_vc];
    assign tok_ret  = pop;
    assign tok_cnt0 = tok[VC_FWD];
    assign tok_cnt1 = tok[VC_BWD];
    assign ovf_err  = err_q;

    AST_ERR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && full[wr_vc]) |=> ovf_err);          // R6
    AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> rd_valid);          // R9
endmodule

// File: tb/tb_vcbuf_top.sv
module tb_vcbuf_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 1'b0, wr_vc = 1'b0, rd_ready = 1'b0;
    logic [91:0] wr_data = '0;
    logic rd_valid, rd_vc, ovf_err;
    logic [91:0] rd_data;
    logic [1:0] tok_ret;
    logic [2:0] tok_cnt0, tok_cnt1;

    int checks = 0, errs = 0, seq = 0;
    bit done = 0;
    logic [91:0] q0[$];
    logic [91:0] q1[$];
    logic mlast = 1'b1;
    logic merr = 1'b0;

    always #10 clk = ~clk;

    vcbuf_top dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_vc(wr_vc),
        .wr_data(wr_data), .rd_ready(rd_ready), .rd_valid(rd_valid),
        .rd_vc(rd_vc), .rd_data(rd_data), .tok_ret(tok_ret),
        .tok_cnt0(tok_cnt0), .tok_cnt1(tok_cnt1), .ovf_err(ovf_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [91:0] mk(input logic ch, input int s);
        return {4'(ch), 24'hC0FFEE, 32'(s) * 32'h9E3779B9, 32'(s)};
    endfunction

    task automatic step(input logic wv, input logic wvc, input logic rr);
        logic [91:0] wd;
        logic ev, evc;
        logic [91:0] ed;
        logic [1:0] eret;
        int s0, s1;
        wd = mk(wvc, seq);
        seq++;
        @(negedge clk);
        wr_valid = wv; wr_vc = wvc; wr_data = wd; rd_ready = rr;
        #1;
        s0 = q0.size(); s1 = q1.size();
        ev  = (s0 > 0) || (s1 > 0);
        evc = (s0 > 0 && s1 > 0) ? ~mlast : (s1 > 0);
        chk(rd_valid == ev, "R8", 96'(rd_valid), 96'(ev));
        if (ev) begin
            ed = evc ? q1[0] : q0[0];
            chk(rd_vc == evc, "R7", 96'(rd_vc), 96'(evc));
            chk(rd_data == ed, "R3", 96'(rd_data), 96'(ed));
        end
        chk(tok_cnt0 == 3'(7 - s0), "R5", 96'(tok_cnt0), 96'(7 - s0));
        chk(tok_cnt1 == 3'(7 - s1), "R5", 96'(tok_cnt1), 96'(7 - s1));
        eret = (rr && ev) ? (2'b01 << evc) : 2'b00;
        chk(tok_ret == eret, "R5", 96'(tok_ret), 96'(eret));
        chk(ovf_err == merr, "R6", 96'(ovf_err), 96'(merr));
        merr = wv && ((wvc ? s1 : s0) == 7);
        if (rr && ev) begin
            mlast = evc;
            if (evc) void'(q1.pop_front()); else void'(q0.pop_front());
        end
        if (wv && !merr) begin
            if (wvc) q1.push_back(wd); else q0.push_back(wd);
        end
    endtask

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(rd_valid == 1'b0, "R1", 96'(rd_valid), 96'd0);
        chk(tok_cnt0 == 3'd7 && tok_cnt1 == 3'd7, "R1", 96'({tok_cnt0, tok_cnt1}), 96'(6'o77));
        chk(ovf_err == 1'b0 && tok_ret == 2'b00, "R1", 96'({ovf_err, tok_ret}), 96'd0);

        // fill forward channel past its limit with link held off (R2, R6)
        for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        chk(tok_cnt0 == 3'd0, "R2", 96'(tok_cnt0), 96'd0);
        // R4: backward channel still accepts while forward is full
        step(1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        chk(tok_cnt1 == 3'd6, "R4", 96'(tok_cnt1), 96'd6);
        for (int i = 0; i < 7; i++) step(1'b1, 1'b1, 1'b0);
        // R9: stalled link keeps everything in place
        step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        chk(tok_cnt0 == 3'd0 && tok_cnt1 == 3'd0, "R9", 96'({tok_cnt0, tok_cnt1}), 96'd0);
        // write to full channel in the same cycle it is read (R6)
        step(1'b1, 1'b0, 1'b1);
        // drain alternating (R7)
        for (int i = 0; i < 16; i++) step(1'b0, 1'b0, 1'b1);
        // single active channel served every cycle (R8)
        for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 1'b1);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b1);

        // pseudo-random sweep biased toward full channels
        lfsr = 16'hACE1;
        for (int i = 0; i < 4000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[1], lfsr[2], (i % 400 < 200) ? (lfsr[3] & lfsr[4]) : (lfsr[3] | lfsr[5]));
        end
        for (int i = 0; i < 20; i++) step(1'b0, 1'b0, 1'b1);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule